// File: doc/BRIEF.md
# Four-Channel Interleaved Successive-Approximation Conversion Sequencer

This block produces all the timing for one recording module. In that module, four amplifier outputs share a single successive-approximation converter. It runs from the module's 10 MHz clock and repeats a fixed frame of 80 cycles. Each frame serves one channel, and the channels are visited in a fixed rotation 0, 1, 2, 3, 0, and so on. A channel is therefore revisited every 320 cycles.

Within a frame, the block does the following:
- It opens a one-hot select window for the channel in service. The same window also powers that channel's source-follower bias.
- It raises a sample strobe inside that window.
- It fires a one-cycle start strobe when sampling ends.
- It enables the comparator only while the bit trials run.

The block also holds the successive-approximation register. That register presents a trial code to the capacitor DAC and takes one comparator decision per cycle. At the end of the trials it hands out the finished code together with the channel number.

The comparator, the DAC and the analog switches are outside this block.

Top module: `sarseq_top`

## Requirements
- R1: After reset, frame cycle 0 is the first clock cycle in which the block runs. Frames are 80 cycles long. Frame k serves channel k mod 4. The select line `ch_sel[k mod 4]` is high in frame cycles 0 to 10 (11 cycles) and low in cycles 11 to 79.
- R2: No more than one bit of `ch_sel` is high in any cycle.
- R3: `smp` is high in frame cycles 1 to 10 (10 cycles) and low otherwise. While `smp` is high, the select line of the channel in service is also high.
- R4: `strt` is high for exactly one cycle per frame, at frame cycle 11. This is the cycle in which `smp` has just fallen.
- R5: `cmp_en` is high in frame cycles 12 to 19 (one cycle per result bit) and low otherwise. It is never high while `smp` is high.
- R6: The bit trials run MSB first, one bit per cycle. In frame cycle 12+j the trial code on `dac_code` has bit 7-j set. That bit stays set when `cmp_hi` is 1 (input at or above the DAC level) and is cleared when `cmp_hi` is 0. For a held input of integer value v (0 to 255), the finished code therefore equals v.
- R7: `res_valid` is high for exactly one cycle per frame, at frame cycle 20. In that cycle `res_code` holds the finished 8-bit code and `res_ch` holds the channel number (0 to 3) of the frame.
- R8: While `rst_n` is low, `ch_sel`, `smp`, `strt`, `cmp_en` and `res_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi | input | 1 | Comparator decision: 1 when the held input is at or above the DAC level |
| ch_sel | output | 4 | One-hot channel select and source-follower bias enable |
| smp | output | 1 | Sample strobe; the input is held when it falls |
| strt | output | 1 | One-cycle start-of-trials strobe |
| cmp_en | output | 1 | Comparator power enable during the bit trials |
| dac_code | output | 8 | Trial code presented to the capacitor DAC |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 8 | Finished conversion code |
| res_ch | output | 2 | Channel number of the finished code |

## Verification
The hardest condition to reach from the ports is a complete bit-trial chain for every possible code, with every channel in the rotation. A single wrong keep-or-clear decision only shows up for the inputs whose binary search passes through that bit. The bench answers each trial with a comparator model that compares the value it held from the channel selected during sampling against `dac_code`. Over 260 consecutive frames it steps the held value through all 256 codes. In each frame the other three channels are driven with the complement of that value, so that a select on the wrong channel yields a wrong code or tag.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
   // Decoded per-cycle strobes of one conversion frame
   typedef struct packed {
      logic win;    // select window open
      logic smp;    // sample strobe
      logic strt;   // start of bit trials
      logic en;     // comparator enable / trial step
      logic done;   // result valid
   } strobe_t;
endpackage

// File: rtl/sarseq_timer.sv
module sarseq_timer #(
   parameter int FRAME_CYC = 80,
   parameter int N_CH      = 4,
   localparam int CYC_W    = $clog2(FRAME_CYC),
   localparam int CH_W     = $clog2(N_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             run,
   output logic [CYC_W-1:0] cyc,
   output logic [CH_W-1:0]  ch
);
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(FRAME_CYC - 1);
   localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(N_CH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cyc <= '0;
         ch  <= '0;
      end else begin
         run <= 1'b1;
         if (run) begin
            if (cyc == CYC_LAST) begin
               cyc <= '0;
               ch  <= (ch == CH_LAST) ? '0 : ch + CH_W'(1);
            end else begin
               cyc <= cyc + CYC_W'(1);
            end
         end
      end
   end

   // R1: the frame counter wraps only from its last value
   assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cyc != CYC_LAST) |=> (cyc == $past(cyc) + CYC_W'(1)));
endmodule

// File: rtl/sarseq_strobes.sv
module sarseq_strobes #(
   parameter int FRAME_CYC = 80,
   parameter int N_CH      = 4,
   parameter int RES       = 8,
   parameter int SMP_CYC   = 10,
   parameter int SEL_LEAD  = 1,
   localparam int CYC_W    = $clog2(FRAME_CYC),
   localparam int CH_W     = $clog2(N_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [CYC_W-1:0]    cyc,
   input  logic [CH_W-1:0]     ch,
   output sarseq_pkg::strobe_t stb,
   output logic [N_CH-1:0]     sel
);
   localparam int SMP_OFF_I  = SEL_LEAD + SMP_CYC;
   localparam int EN_FROM_I  = SMP_OFF_I + 1;
   localparam int EN_TO_I    = EN_FROM_I + RES - 1;
   localparam int DONE_I     = EN_TO_I + 1;

   localparam logic [CYC_W-1:0] SMP_ON  = CYC_W'(SEL_LEAD);
   localparam logic [CYC_W-1:0] SMP_OFF = CYC_W'(SMP_OFF_I);
   localparam logic [CYC_W-1:0] EN_FROM = CYC_W'(EN_FROM_I);
   localparam logic [CYC_W-1:0] EN_TO   = CYC_W'(EN_TO_I);
   localparam logic [CYC_W-1:0] DONE_AT = CYC_W'(DONE_I);

   if (DONE_I >= FRAME_CYC) begin : g_bad_frame
      $error("frame too short for sampling plus %0d trials", RES);
   end

   always_comb begin
      stb.win  = run && (cyc < SMP_OFF);
      stb.smp  = run && (cyc >= SMP_ON) && (cyc < SMP_OFF);
      stb.strt = run && (cyc == SMP_OFF);
      stb.en   = run && (cyc >= EN_FROM) && (cyc <= EN_TO);
      stb.done = run && (cyc == DONE_AT);
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_sel
      assign sel[i] = stb.win && (ch == CH_W'(i));
   end

   // R2: never two channels driving the converter input
   assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   // R3: sampling only inside an open select window
   assert_smp_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb.smp |-> (sel != '0));
   // R4: trials start exactly when sampling ends
   assert_strt_after_smp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stb.smp) |-> stb.strt);
   // R5: comparator powered right after the start strobe, never while sampling
   assert_en_follows_strt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stb.strt |=> (stb.en && !stb.smp));
endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar #(
   parameter int N_CH     = 4,
   parameter int RES      = 8,
   localparam int CH_W    = $clog2(N_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic            cmp_hi,
   input  logic [CH_W-1:0] ch_in,
   output logic [RES-1:0]  acc,
   output logic [CH_W-1:0] ch_tag
);
   logic [RES-1:0] ptr;   // one-hot marker of the bit under trial
   localparam logic [RES-1:0] MSB = RES'(1) << (RES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         ptr    <= '0;
         ch_tag <= '0;
      end else if (load) begin
         acc    <= MSB;
         ptr    <= MSB;
         ch_tag <= ch_in;
      end else if (step && ptr != '0) begin
         acc <= (cmp_hi ? acc : (acc & ~ptr)) | (ptr >> 1);
         ptr <= ptr >> 1;
      end
   end

   // R6: a trial only ever touches the bit under test and the one below it
   assert_trial_keeps_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && ptr != '0 && cmp_hi) |=> ((acc & $past(acc)) == $past(acc)));
endmodule

// File: rtl/sarseq_top.sv
module sarseq_top #(
   parameter int FRAME_CYC = 80,
   parameter int N_CH      = 4,
   parameter int RES       = 8,
   parameter int SMP_CYC   = 10,
   parameter int SEL_LEAD  = 1,
   localparam int CYC_W    = $clog2(FRAME_CYC),
   localparam int CH_W     = $clog2(N_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmp_hi,
   output logic [N_CH-1:0] ch_sel,
   output logic            smp,
   output logic            strt,
   output logic            cmp_en,
   output logic [RES-1:0]  dac_code,
   output logic            res_valid,
   output logic [RES-1:0]  res_code,
   output logic [CH_W-1:0] res_ch
);
   if (N_CH < 2 || (N_CH & (N_CH - 1)) != 0) begin : g_bad_nch
      $error("channel count must be a power of two, at least 2");
   end
   if (SEL_LEAD < 1 || SMP_CYC < 1 || RES < 2) begin : g_bad_timing
      $error("select lead, sample width and resolution must be positive");
   end

   logic                run;
   logic [CYC_W-1:0]    cyc;
   logic [CH_W-1:0]     ch;
   sarseq_pkg::strobe_t stb;

   sarseq_timer #(.FRAME_CYC(FRAME_CYC), .N_CH(N_CH)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .cyc(cyc), .ch(ch));

   sarseq_strobes #(.FRAME_CYC(FRAME_CYC), .N_CH(N_CH), .RES(RES),
                    .SMP_CYC(SMP_CYC), .SEL_LEAD(SEL_LEAD)) u_strobes (
      .clk(clk), .rst_n(rst_n), .run(run), .cyc(cyc), .ch(ch),
      .stb(stb), .sel(ch_sel));

   sarseq_sar #(.N_CH(N_CH), .RES(RES)) u_sar (
      .clk(clk), .rst_n(rst_n), .load(stb.strt), .step(stb.en),
      .cmp_hi(cmp_hi), .ch_in(ch), .acc(dac_code), .ch_tag(res_ch));

   assign smp       = stb.smp;
   assign strt      = stb.strt;
   assign cmp_en    = stb.en;
   assign res_valid = stb.done;
   assign res_code  = dac_code;

   // R7: a result is announced only right after the last trial
   assert_valid_after_trials_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($past(cmp_en) && !cmp_en));
   // R8: nothing is driven while held in reset
   always_comb begin
      if (!rst_n) begin
         assert_quiet_in_reset_R8: assert (ch_sel == '0 && !smp && !strt && !cmp_en && !res_valid);
      end
   end
endmodule

// File: tb/sim_sarseq_top.sv
module sim_sarseq_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_hi;
   logic [3:0] ch_sel;
   logic       smp, strt, cmp_en, res_valid;
   logic [7:0] dac_code, res_code;
   logic [1:0] res_ch;

   logic [7:0] vin [4];
   logic [7:0] held = 8'd0;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   assign cmp_hi = (held >= dac_code);   // comparator model

   sarseq_top u0 (
      .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .ch_sel(ch_sel), .smp(smp),
      .strt(strt), .cmp_en(cmp_en), .dac_code(dac_code), .res_valid(res_valid),
      .res_code(res_code), .res_ch(res_ch));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int j = 0; j < 4; j++) vin[j] = 8'd0;
      // R8: reset state
      repeat (3) @(negedge clk);
      chk("R8", "ch_sel in reset", int'(ch_sel), 0);
      chk("R8", "smp in reset", int'(smp), 0);
      chk("R8", "strt in reset", int'(strt), 0);
      chk("R8", "cmp_en in reset", int'(cmp_en), 0);
      chk("R8", "res_valid in reset", int'(res_valid), 0);
      rst_n = 1'b1;
      for (int f = 0; f < 260; f++) begin
         int ch;
         logic [7:0] val;
         ch  = f % 4;
         val = 8'(f);
         for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (c == 0) begin
               for (int j = 0; j < 4; j++) vin[j] = (j == ch) ? val : ~val;
            end
            for (int j = 0; j < 4; j++) if (smp && ch_sel[j]) held = vin[j];
            // R1: select window of the served channel only
            chk("R1", "ch_sel", int'(ch_sel), (c <= 10) ? (1 << ch) : 0);
            // R3: sample strobe
            chk("R3", "smp", int'(smp), (c >= 1 && c <= 10) ? 1 : 0);
            // R4: start strobe
            chk("R4", "strt", int'(strt), (c == 11) ? 1 : 0);
            // R5: comparator enable
            chk("R5", "cmp_en", int'(cmp_en), (c >= 12 && c <= 19) ? 1 : 0);
            // R2: at most one select
            chk("R2", "select count", $countones(ch_sel), (c <= 10) ? 1 : 0);
            // R6: MSB-first trial code carries the bit under test
            if (c >= 12 && c <= 19) begin
               int b;
               b = 19 - c;
               chk("R6", "trial bit set", int'(dac_code[b]), 1);
               chk("R6", "upper bits", int'(dac_code >> (b + 1)), int'(val >> (b + 1)));
            end
            // R7: result strobe, code and tag
            chk("R7", "res_valid", int'(res_valid), (c == 20) ? 1 : 0);
            if (c == 20) begin
               chk("R6", "code", int'(res_code), int'(val));
               chk("R7", "channel tag", int'(res_ch), ch);
            end
         end
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule